// File: doc/BRIEF.md
# SPI Slave with Deferred Write Commit

This block is the serial front end of a small register and memory device. It watches a mode-0 SPI bus (clock idle low, input captured on the rising clock edge, output moved after the falling edge) that is oversampled by a faster system clock. It decodes an opcode byte, an address byte and any number of data bytes. A read streams bytes from the attached storage onto the serial output, starting at the given address and moving to the next address after each byte. A write does not reach storage while it is being received. The data bytes go into a small staging buffer instead.

A write is committed only when chip select is released at the end of a complete, valid write frame. A valid frame needs a write-enable latch that an earlier, separate frame has set, and at least one whole data byte with no trailing partial byte. The commit then runs as a fixed-length internal programming cycle. During that cycle the block flags busy, copies the staged bytes to the storage write port and ignores chip select completely. When the cycle ends, the write-enable latch clears.

After reset the slave is locked. The first period with chip select low only arms it, and frames are accepted from the next chip-select falling edge on.

Top module: `spi_wc_slave`

## Requirements
- R1: A frame begins only at a chip-select falling edge seen while the slave is armed and not busy. Returning chip select high ends the frame and puts the slave back in standby.
- R2: While chip select is high the serial output enable `so_oe` is low. It is high only while a read frame is streaming data.
- R3: `si` is captured on each rising `sck` edge, MSB first. Opcode 0x06 sets the write-enable latch, 0x12 starts a write and 0x13 starts a read, each followed by an 8-bit address. Any other opcode makes the rest of the frame have no effect until chip select is raised.
- R4: `so` changes only after a falling `sck` edge. Read data goes out MSB first, and its first bit appears after the falling edge that follows the last address bit.
- R5: Read and write addresses advance by one after each data byte and wrap from 0xFF to 0x00.
- R6: A write is committed on the chip-select rising edge only if the write-enable latch is set, at least one whole data byte was received and no partial byte follows. Otherwise nothing is written and busy stays low.
- R7: A commit raises `busy` for exactly `PROG_CYCLES` clock cycles, starting two clocks after `cs_n` goes high. During that window the staged bytes appear on the write port in order, one per cycle, and `wr_en` is never high outside it.
- R8: While busy the slave ignores chip select. A falling edge during the cycle starts no frame, and a new falling edge after busy drops is needed.
- R9: The write-enable latch clears when a programming cycle completes. A discarded write leaves the latch as it was.
- R10: After reset, the first low period of chip select only arms the slave. Opcodes sent in it have no effect.
- R11: Data bytes beyond `BUF_DEPTH` in one write frame are dropped, and only the first `BUF_DEPTH` bytes are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data into the slave |
| so | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| rd_addr | output | 8 | Storage read address |
| rd_data | input | 8 | Storage read data, combinational from `rd_addr` |
| wr_en | output | 1 | Storage write strobe |
| wr_addr | output | 8 | Storage write address |
| wr_data | output | 8 | Storage write data |
| busy | output | 1 | Internal programming cycle in progress |

## Verification
The end of a programming cycle and a chip-select falling edge can land in the same clock. When they do, the busy flag about to drop decides whether a new frame opens. The bench commits a one-byte write, then lowers chip select at offsets from `PROG_CYCLES-1` to `PROG_CYCLES+2` clocks after releasing it, and issues a read in the new frame. The read must be silent (output enable never high) for every offset that meets the last busy cycle or an earlier one. It must return the freshly committed byte for every later offset.

// File: rtl/spi_wc_pkg.sv
package spi_wc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_RADDR,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } frame_st_e;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRITE = 8'h12;
    localparam logic [7:0] OPC_READ  = 8'h13;

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
    } pin_ev_t;

    function automatic logic [7:0] addr_step(input logic [7:0] a);
        return a + 8'd1;
    endfunction

endpackage

// File: rtl/spi_wc_edge.sv
module spi_wc_edge
    import spi_wc_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    din,
    output pin_ev_t ev
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= IDLE_LVL;
            s2 <= IDLE_LVL;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    assign ev.rise  = s1 & ~s2;
    assign ev.fall  = ~s1 & s2;
    assign ev.level = s1;
endmodule

// File: rtl/spi_wc_wbuf.sv
module spi_wc_wbuf #(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] count
);
    logic [7:0] mem [DEPTH];
    logic       room;

    assign room = (count < CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && room) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!clear && push && room) begin
            mem[count[IW-1:0]] <= push_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/spi_wc_prog.sv
module spi_wc_prog #(
    parameter int DEPTH       = 4,
    parameter int PROG_CYCLES = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] n_bytes,
    input  logic [7:0]    base,
    output logic [IW-1:0] rd_idx,
    output logic          busy,
    output logic          wr_en,
    output logic [7:0]    wr_addr,
    output logic          done
);
    logic          active;
    logic [PW-1:0] cyc;
    logic [CW-1:0] n_q;
    logic [7:0]    base_q;

    assign done = active && (cyc == PW'(PROG_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cyc    <= '0;
            n_q    <= '0;
            base_q <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cyc    <= '0;
                n_q    <= n_bytes;
                base_q <= base;
            end
        end else if (done) begin
            active <= 1'b0;
        end else begin
            cyc <= cyc + PW'(1);
        end
    end

    assign busy    = active;
    assign wr_en   = active && (int'(cyc) < int'(n_q));
    assign wr_addr = base_q + 8'(cyc);
    assign rd_idx  = IW'(cyc);
endmodule

// File: rtl/spi_wc_slave.sv
module spi_wc_slave
    import spi_wc_pkg::*;
#(
    parameter int BUF_DEPTH   = 4,
    parameter int PROG_CYCLES = 16,
    localparam int IW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       so,
    output logic       so_oe,
    output logic [7:0] rd_addr,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       busy
);
    pin_ev_t e_sck, e_cs, e_si;

    spi_wc_edge #(.IDLE_LVL(1'b0)) u_sck_ev (.clk(clk), .rst(rst), .din(sck),  .ev(e_sck));
    spi_wc_edge #(.IDLE_LVL(1'b1)) u_cs_ev  (.clk(clk), .rst(rst), .din(cs_n), .ev(e_cs));
    spi_wc_edge #(.IDLE_LVL(1'b0)) u_si_ev  (.clk(clk), .rst(rst), .din(si),   .ev(e_si));

    logic unused_ev;
    assign unused_ev = &{e_sck.level, e_si.rise, e_si.fall};

    frame_st_e     state;
    logic [2:0]    bitcnt;
    logic [6:0]    shin;
    logic [6:0]    txsh;
    logic [7:0]    addr;
    logic [7:0]    wbase;
    logic          wel;
    logic          armed;
    logic          so_q;
    logic [7:0]    byte_in;
    logic          byte_end;
    logic          frame_open;
    logic          buf_push;
    logic          commit;
    logic [IW-1:0] buf_idx;
    logic [CW-1:0] buf_cnt;
    logic          prog_done;

    assign byte_in    = {shin, e_si.level};
    assign byte_end   = e_sck.rise && (bitcnt == 3'd7);
    assign frame_open = e_cs.fall && armed && !busy;
    assign buf_push   = (state == ST_WDATA) && byte_end && !e_cs.rise && !e_cs.fall;
    assign commit     = e_cs.rise && (state == ST_WDATA) && wel
                        && (bitcnt == 3'd0) && (buf_cnt != '0);

    spi_wc_wbuf #(.DEPTH(BUF_DEPTH)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .clear    (frame_open),
        .push     (buf_push),
        .push_data(byte_in),
        .rd_idx   (buf_idx),
        .rd_data  (wr_data),
        .count    (buf_cnt)
    );

    spi_wc_prog #(.DEPTH(BUF_DEPTH), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk    (clk),
        .rst    (rst),
        .start  (commit),
        .n_bytes(buf_cnt),
        .base   (wbase),
        .rd_idx (buf_idx),
        .busy   (busy),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .done   (prog_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shin   <= '0;
            txsh   <= '0;
            addr   <= '0;
            wbase  <= '0;
            wel    <= 1'b0;
            armed  <= 1'b0;
            so_q   <= 1'b0;
        end else begin
            if (prog_done) wel <= 1'b0;

            if (e_cs.rise) begin
                armed <= 1'b1;
                state <= ST_IDLE;
            end else if (e_cs.fall) begin
                if (frame_open) begin
                    state  <= ST_OPC;
                    bitcnt <= '0;
                end
            end else if (e_sck.rise && state != ST_IDLE && state != ST_SKIP) begin
                bitcnt <= bitcnt + 3'd1;
                shin   <= {shin[5:0], e_si.level};
                if (bitcnt == 3'd7) begin
                    unique case (state)
                        ST_OPC: begin
                            if (byte_in == OPC_WREN) begin
                                wel   <= 1'b1;
                                state <= ST_SKIP;
                            end else if (byte_in == OPC_WRITE && wel) begin
                                state <= ST_WADDR;
                            end else if (byte_in == OPC_READ) begin
                                state <= ST_RADDR;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_WADDR: begin
                            wbase <= byte_in;
                            state <= ST_WDATA;
                        end
                        ST_RADDR: begin
                            addr  <= byte_in;
                            state <= ST_RDATA;
                        end
                        ST_RDATA: addr <= addr_step(addr);
                        default: ;
                    endcase
                end
            end else if (e_sck.fall && state == ST_RDATA) begin
                if (bitcnt == 3'd0) begin
                    so_q <= rd_data[7];
                    txsh <= rd_data[6:0];
                end else begin
                    so_q <= txsh[6];
                    txsh <= {txsh[5:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr = addr;
    assign so      = so_q;
    assign so_oe   = (state == ST_RDATA) && !e_cs.level;
endmodule

// File: rtl/spi_wc_checks.sv
module spi_wc_checks #(
    parameter int PROG_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic sck,
    input logic cs_n,
    input logic so,
    input logic so_oe,
    input logic wr_en,
    input logic busy
);
    int bcnt;

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    assert_oe_off_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !so_oe);

    assert_so_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(so) |-> !$past(sck));

    assert_commit_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_n));

    assert_write_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (bcnt == PROG_CYCLES));

    assert_no_output_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !so_oe);
endmodule

bind spi_wc_slave spi_wc_checks #(.PROG_CYCLES(PROG_CYCLES)) u_checks (
    .clk  (clk),
    .rst  (rst),
    .sck  (sck),
    .cs_n (cs_n),
    .so   (so),
    .so_oe(so_oe),
    .wr_en(wr_en),
    .busy (busy)
);

// File: tb/spi_wc_slave_tb.sv
`timescale 1ns/1ps
module spi_wc_slave_tb;
    localparam int DEPTH = 4;
    localparam int PROG  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       so, so_oe, wr_en, busy;
    logic [7:0] rd_addr, wr_addr, wr_data;
    logic [7:0] rd_data;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    bit         wel_m   = 1'b0;
    bit         armed_m = 1'b0;
    int         nvec = 0;
    int         nbad = 0;
    bit         oe_all, oe_any;

    always #2.5 clk = ~clk;

    spi_wc_slave #(.BUF_DEPTH(DEPTH), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
    );

    assign rd_data = mem[rd_addr];

    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic r);
        sck = 1'b0;
        si  = b;
        half();
        r = so;
        oe_all &= so_oe;
        oe_any |= so_oe;
        sck = 1'b1;
        half();
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            send_bit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        half();
        oe_all = 1'b1;
        oe_any = 1'b0;
    endtask

    task automatic cs_high();
        sck = 1'b0;
        half();
        cs_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic mem_cmp(input string req);
        int diff = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) diff++;
        chk(req, diff, 0);
    endtask

    task automatic do_wren();
        logic [7:0] rx;
        cs_low();
        xfer(8'h06, rx);
        cs_high();
        if (armed_m) wel_m = 1'b1;
        armed_m = 1'b1;
        settle();
    endtask

    // write of n whole bytes plus pbits trailing bits
    task automatic do_write(input logic [7:0] a, input int n, input int pbits);
        logic [7:0] rx, d;
        logic       r;
        bit         ok;
        cs_low();
        xfer(8'h12, rx);
        xfer(a, rx);
        ok = armed_m && wel_m && n > 0 && pbits == 0;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            xfer(d, rx);
            if (ok && i < DEPTH) exp_mem[8'(a + 8'(i))] = d;
        end
        for (int i = 0; i < pbits; i++) send_bit(1'($urandom), r);
        cs_high();
        armed_m = 1'b1;
        repeat (2) @(negedge clk);
        chk(ok ? "R6 commit starts busy" : "R6 discarded write no busy", busy, ok);
        if (ok) begin
            repeat (PROG - 1) @(negedge clk);
            chk("R7 busy still high at last cycle", busy, 1);
            @(negedge clk);
            chk("R7 busy low after window", busy, 0);
            wel_m = 1'b0;
        end
        settle();
        mem_cmp(ok ? "R11 R5 committed storage" : "R6 storage untouched");
    endtask

    task automatic do_read(input logic [7:0] a, input int n);
        logic [7:0] rx;
        cs_low();
        xfer(8'h13, rx);
        xfer(a, rx);
        chk("R2 oe low during command", oe_any, 0);
        for (int i = 0; i < n; i++) begin
            oe_all = 1'b1;
            xfer(8'h00, rx);
            chk("R4 R5 read byte", rx, exp_mem[8'(a + 8'(i))]);
            chk("R2 oe high while streaming", oe_all, armed_m);
        end
        cs_high();
        armed_m = 1'b1;
        settle();
        chk("R2 oe low after deselect", so_oe, 0);
    endtask

    task automatic do_badop(input logic [7:0] op);
        logic [7:0] rx;
        cs_low();
        xfer(op, rx);
        xfer(8'h13, rx);
        xfer(8'h00, rx);
        cs_high();
        armed_m = 1'b1;
        settle();
        chk("R3 unknown opcode silent", oe_any, 0);
        chk("R3 unknown opcode no busy", busy, 0);
    endtask

    // lower cs d clocks after releasing it from a committed write
    task automatic overlap(input int d);
        logic [7:0] rx, dat;
        bit         acc;
        do_wren();
        cs_low();
        xfer(8'h12, rx);
        xfer(8'h40, rx);
        dat = 8'($urandom);
        xfer(dat, rx);
        cs_high();
        exp_mem[8'h40] = dat;
        wel_m = 1'b0;
        repeat (d) @(negedge clk);
        cs_n = 1'b0;
        half();
        oe_all = 1'b1;
        oe_any = 1'b0;
        acc = (d >= PROG + 1);
        xfer(8'h13, rx);
        xfer(8'h40, rx);
        oe_all = 1'b1;
        xfer(8'h00, rx);
        cs_high();
        settle();
        if (acc) begin
            chk("R1 frame after busy accepted", oe_all, 1);
            chk("R1 read sees new byte", rx, dat);
        end else begin
            chk("R8 frame during busy ignored", oe_any, 0);
        end
        mem_cmp("R7 overlap storage");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset oe", so_oe, 0);
        chk("R7 reset busy", busy, 0);
        chk("R7 reset wr_en", wr_en, 0);

        // R10: first frame only arms, so this enable is lost
        do_wren();
        chk("R10 lock frame left no latch", wel_m, 0);
        do_write(8'h10, 2, 0);
        do_wren();
        do_write(8'hFE, 6, 0);          // R5 wrap and R11 overflow
        do_read(8'hFD, 8);
        do_write(8'h20, 1, 0);          // R9 latch cleared by commit
        do_wren();
        do_write(8'h30, 2, 3);          // R6 partial byte
        do_write(8'h30, 0, 0);          // R6 no data byte
        do_write(8'h31, 3, 0);          // R9 latch kept after discard
        do_read(8'h30, 4);
        do_badop(8'hA5);
        do_wren();
        do_badop(8'h03);
        do_write(8'h50, 1, 0);          // R3 latch survives unknown opcode
        for (int d = PROG - 1; d <= PROG + 2; d++) overlap(d);

        for (int it = 0; it < 30; it++) begin
            int k = int'($urandom_range(0, 4));
            case (k)
                0: do_wren();
                1: do_write(8'($urandom), int'($urandom_range(1, 6)), 0);
                2: do_write(8'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(1, 7)));
                3: do_read(8'($urandom), int'($urandom_range(1, 5)));
                default: do_badop(8'($urandom_range(32, 255)));
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule